// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache with Aged Replacement

This block is a data cache that sits between a 32-bit processor load/store port and a word-wide memory port. It holds 256 sets, each with two ways of one 32-bit word. Every way of a set carries a tag, a valid flag, a dirty flag and a recently-used flag. A request looks up both ways of the addressed set at once. A load hit returns its word in the same cycle, and a store hit updates the word in place and marks it modified without any memory traffic.

On a miss the cache stalls the processor and picks a way to replace. An empty way is always taken first. Otherwise the cache takes a way whose recently-used flag is clear. A free-running aging counter wipes all of these flags at a fixed interval, so "clear" means "not touched since the last wipe". This gives an approximation of least-recently-used order at the cost of one flag per way. A modified victim is first written back to memory, and then the requested word is read in. A store miss allocates the line and then writes it. The processor keeps its request steady while the stall is high.

Top module: `sa2_wb_cache`

## Requirements
- R1: Address bits [1:0] do not take part in word selection; bits [9:2] pick the set and bits [31:10] form the tag, so loads to any byte offset of a cached word hit without memory traffic.
- R2: Both ways of the selected set are compared in parallel; at most one way matches, and a load hit drives the stored word on `cpu_rdata` with `cpu_stall` low in the same cycle.
- R3: Reset clears every valid flag, so the first access to any address misses and reads memory.
- R4: A store hit updates the word and sets the way's dirty flag with no memory traffic; the stored value is read back by later loads.
- R5: A miss whose victim is valid and dirty issues a memory write (`mem_we`=1) of the victim's word to the victim's own address, and only after its acknowledge issues the memory read for the new word.
- R6: A miss whose victim is clean or invalid issues only the memory read; the victim is overwritten without a write.
- R7: Victim order: an invalid way first (way 0 before way 1), then a valid way whose used flag is clear (way 0 before way 1), and way 0 when both used flags are set.
- R8: A hit sets the used flag of the hit way; every AGE_PERIOD (default 1024) cycles after reset the aging counter clears all used flags, with a hit in the same cycle still setting its own flag.
- R9: From the miss cycle until the fill acknowledge `cpu_stall` is high; in the cycle after the fill the held request hits, and a store miss then writes its data into the freshly allocated, now dirty, line.
- R10: `mem_req` is high only during write-back and fill, and `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid on a hit |
| cpu_stall | output | 1 | Access not finished this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory completes the current access this cycle |
| mem_rdata | input | 32 | Fill data, valid with `mem_ack` on a read |

## Verification
A load hit is due in the very cycle of the request, since lookup and data selection are combinational, while a store hit becomes visible at the next access. A miss raises the stall in its request cycle, puts the memory request out from the next cycle until the acknowledge, and releases the stall one cycle after the fill acknowledge. A behavioural model in the bench advances once per clock with the same inputs and predicts stall, read data and every memory request field; all of them are compared a nanosecond after each falling edge, when inputs driven at that edge have settled. Directed sequences line up aging wipes with the model's own interval counter so that each victim-order case is reached in a known state.

// File: rtl/sa2c_pkg.sv
package sa2c_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int BYTE_OFF_W = 2;
    localparam int N_WAYS     = 2;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_WRBACK = 2'd1,
        CS_REFILL = 2'd2
    } cstate_e;

    typedef struct packed {
        logic [N_WAYS-1:0] valid;
        logic [N_WAYS-1:0] dirty;
        logic [N_WAYS-1:0] used;
    } set_status_t;

    // Empty way first, then a way not touched since the last aging wipe,
    // and way 0 when every way is recently used.
    function automatic logic choose_victim(input set_status_t s);
        if (!s.valid[0]) return 1'b0;
        if (!s.valid[1]) return 1'b1;
        if (!s.used[0])  return 1'b0;
        if (!s.used[1])  return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/sa2c_tag_store.sv
module sa2c_tag_store
    import sa2c_pkg::*;
#(
    parameter int SETS  = 256,
    parameter int IDX_W = 8,
    parameter int TAG_W = 22
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDX_W-1:0]          look_idx,
    input  logic [TAG_W-1:0]          look_tag,
    input  logic                      fill_en,
    input  logic                      fill_way,
    input  logic [TAG_W-1:0]          fill_tag,
    input  logic                      mark_en,
    input  logic                      mark_way,
    output logic [N_WAYS-1:0]         hit_vec,
    output logic [N_WAYS-1:0]         valid_vec,
    output logic [N_WAYS-1:0]         dirty_vec,
    output logic [N_WAYS*TAG_W-1:0]   tags_flat
);

    for (genvar w = 0; w < N_WAYS; w++) begin : g_way
        localparam logic WAY_ID = 1'(w);

        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  val_q;
        logic [SETS-1:0]  dirty_q;

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == WAY_ID) begin
                tag_q[look_idx] <= fill_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q   <= '0;
                dirty_q <= '0;
            end else if (fill_en && fill_way == WAY_ID) begin
                val_q[look_idx]   <= 1'b1;
                dirty_q[look_idx] <= 1'b0;
            end else if (mark_en && mark_way == WAY_ID) begin
                dirty_q[look_idx] <= 1'b1;
            end
        end

        assign valid_vec[w] = val_q[look_idx];
        assign dirty_vec[w] = dirty_q[look_idx];
        assign tags_flat[w*TAG_W +: TAG_W] = tag_q[look_idx];
        assign hit_vec[w]   = val_q[look_idx] && (tag_q[look_idx] == look_tag);
    end

endmodule

// File: rtl/sa2c_data_store.sv
module sa2c_data_store
    import sa2c_pkg::*;
#(
    parameter int SETS  = 256,
    parameter int IDX_W = 8
) (
    input  logic                      clk,
    input  logic [IDX_W-1:0]          idx,
    input  logic                      we,
    input  logic                      way,
    input  logic [WORD_W-1:0]         wdata,
    output logic [N_WAYS*WORD_W-1:0]  rdata_flat
);

    for (genvar w = 0; w < N_WAYS; w++) begin : g_way
        localparam logic WAY_ID = 1'(w);

        logic [WORD_W-1:0] word_q [SETS];

        always_ff @(posedge clk) begin
            if (we && way == WAY_ID) begin
                word_q[idx] <= wdata;
            end
        end

        assign rdata_flat[w*WORD_W +: WORD_W] = word_q[idx];
    end

endmodule

// File: rtl/sa2c_age_unit.sv
module sa2c_age_unit
    import sa2c_pkg::*;
#(
    parameter int SETS       = 256,
    parameter int IDX_W      = 8,
    parameter int AGE_PERIOD = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   idx,
    input  logic               touch_en,
    input  logic               touch_way,
    output logic [N_WAYS-1:0]  use_vec
);

    localparam int CNT_W = (AGE_PERIOD > 2) ? $clog2(AGE_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(AGE_PERIOD - 1);

    logic [CNT_W-1:0]  age_cnt;
    logic              age_tick;
    logic [N_WAYS-1:0] use_q [SETS];

    assign age_tick = (age_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            age_cnt <= '0;
        end else if (age_tick) begin
            age_cnt <= '0;
        end else begin
            age_cnt <= age_cnt + 1'b1;
        end
    end

    // A wipe and a touch in one cycle: the later assignment keeps the touch.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                use_q[s] <= '0;
            end
        end else begin
            if (age_tick) begin
                for (int s = 0; s < SETS; s++) begin
                    use_q[s] <= '0;
                end
            end
            if (touch_en) begin
                use_q[idx][touch_way] <= 1'b1;
            end
        end
    end

    assign use_vec = use_q[idx];

endmodule

// File: rtl/sa2c_ctrl.sv
module sa2c_ctrl
    import sa2c_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int TAG_W = 22
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cpu_req,
    input  logic                      cpu_we,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [WORD_W-1:0]         cpu_wdata,
    input  logic [N_WAYS-1:0]         hit_vec,
    input  logic [N_WAYS-1:0]         valid_vec,
    input  logic [N_WAYS-1:0]         dirty_vec,
    input  logic [N_WAYS-1:0]         use_vec,
    input  logic [N_WAYS*TAG_W-1:0]   tags_flat,
    input  logic [N_WAYS*WORD_W-1:0]  rdata_flat,
    input  logic                      mem_ack,
    input  logic [WORD_W-1:0]         mem_rdata,
    output logic [IDX_W-1:0]          look_idx,
    output logic [TAG_W-1:0]          look_tag,
    output logic                      cpu_stall,
    output logic                      hit_way,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [WORD_W-1:0]         mem_wdata,
    output logic                      tag_fill_en,
    output logic                      tag_fill_way,
    output logic                      dirty_mark_en,
    output logic                      dirty_mark_way,
    output logic                      data_we,
    output logic                      data_way,
    output logic [WORD_W-1:0]         data_wdata,
    output logic                      touch_en,
    output logic                      touch_way
);

    cstate_e          state_q;
    logic             vic_q;
    logic [IDX_W-1:0] lat_idx_q;
    logic [TAG_W-1:0] lat_tag_q;

    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             any_hit;
    logic             acc_hit;
    logic             acc_miss;
    logic             vic_sel;
    set_status_t      set_stat;
    logic             unused_offset;

    assign req_idx       = cpu_addr[BYTE_OFF_W +: IDX_W];
    assign req_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^cpu_addr[BYTE_OFF_W-1:0];

    assign look_idx = (state_q == CS_IDLE) ? req_idx : lat_idx_q;
    assign look_tag = (state_q == CS_IDLE) ? req_tag : lat_tag_q;

    assign any_hit  = |hit_vec;
    assign acc_hit  = (state_q == CS_IDLE) && cpu_req && any_hit;
    assign acc_miss = (state_q == CS_IDLE) && cpu_req && !any_hit;
    assign hit_way  = hit_vec[1];

    assign set_stat = '{valid: valid_vec, dirty: dirty_vec, used: use_vec};
    assign vic_sel  = choose_victim(set_stat);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= CS_IDLE;
            vic_q     <= 1'b0;
            lat_idx_q <= '0;
            lat_tag_q <= '0;
        end else begin
            unique case (state_q)
                CS_IDLE: begin
                    if (acc_miss) begin
                        vic_q     <= vic_sel;
                        lat_idx_q <= req_idx;
                        lat_tag_q <= req_tag;
                        state_q   <= (valid_vec[vic_sel] && dirty_vec[vic_sel])
                                     ? CS_WRBACK : CS_REFILL;
                    end
                end
                CS_WRBACK: begin
                    if (mem_ack) state_q <= CS_REFILL;
                end
                CS_REFILL: begin
                    if (mem_ack) state_q <= CS_IDLE;
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    assign cpu_stall = (state_q != CS_IDLE) || acc_miss;

    assign mem_req   = (state_q == CS_WRBACK) || (state_q == CS_REFILL);
    assign mem_we    = (state_q == CS_WRBACK);
    assign mem_addr  = (state_q == CS_WRBACK)
                     ? {tags_flat[vic_q*TAG_W +: TAG_W], lat_idx_q, {BYTE_OFF_W{1'b0}}}
                     : {lat_tag_q, lat_idx_q, {BYTE_OFF_W{1'b0}}};
    assign mem_wdata = rdata_flat[vic_q*WORD_W +: WORD_W];

    assign tag_fill_en    = (state_q == CS_REFILL) && mem_ack;
    assign tag_fill_way   = vic_q;
    assign dirty_mark_en  = acc_hit && cpu_we;
    assign dirty_mark_way = hit_way;

    assign data_we    = (acc_hit && cpu_we) || tag_fill_en;
    assign data_way   = (state_q == CS_REFILL) ? vic_q : hit_way;
    assign data_wdata = (state_q == CS_REFILL) ? mem_rdata : cpu_wdata;

    assign touch_en  = acc_hit;
    assign touch_way = hit_way;

endmodule

// File: rtl/sa2_wb_cache.sv
module sa2_wb_cache
    import sa2c_pkg::*;
#(
    parameter int SETS       = 256,
    parameter int AGE_PERIOD = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [WORD_W-1:0]   cpu_wdata,
    output logic [WORD_W-1:0]   cpu_rdata,
    output logic                cpu_stall,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - BYTE_OFF_W;

    logic [IDX_W-1:0]          look_idx;
    logic [TAG_W-1:0]          look_tag;
    logic [N_WAYS-1:0]         hit_vec;
    logic [N_WAYS-1:0]         valid_vec;
    logic [N_WAYS-1:0]         dirty_vec;
    logic [N_WAYS-1:0]         use_vec;
    logic [N_WAYS*TAG_W-1:0]   tags_flat;
    logic [N_WAYS*WORD_W-1:0]  rdata_flat;
    logic                      hit_way;
    logic                      tag_fill_en;
    logic                      tag_fill_way;
    logic                      dirty_mark_en;
    logic                      dirty_mark_way;
    logic                      data_we;
    logic                      data_way;
    logic [WORD_W-1:0]         data_wdata;
    logic                      touch_en;
    logic                      touch_way;

    sa2c_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk       (clk),
        .rst       (rst),
        .look_idx  (look_idx),
        .look_tag  (look_tag),
        .fill_en   (tag_fill_en),
        .fill_way  (tag_fill_way),
        .fill_tag  (look_tag),
        .mark_en   (dirty_mark_en),
        .mark_way  (dirty_mark_way),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .tags_flat (tags_flat)
    );

    sa2c_data_store #(.SETS(SETS), .IDX_W(IDX_W)) data_i (
        .clk        (clk),
        .idx        (look_idx),
        .we         (data_we),
        .way        (data_way),
        .wdata      (data_wdata),
        .rdata_flat (rdata_flat)
    );

    sa2c_age_unit #(.SETS(SETS), .IDX_W(IDX_W), .AGE_PERIOD(AGE_PERIOD)) age_i (
        .clk       (clk),
        .rst       (rst),
        .idx       (look_idx),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .use_vec   (use_vec)
    );

    sa2c_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) ctrl_i (
        .clk            (clk),
        .rst            (rst),
        .cpu_req        (cpu_req),
        .cpu_we         (cpu_we),
        .cpu_addr       (cpu_addr),
        .cpu_wdata      (cpu_wdata),
        .hit_vec        (hit_vec),
        .valid_vec      (valid_vec),
        .dirty_vec      (dirty_vec),
        .use_vec        (use_vec),
        .tags_flat      (tags_flat),
        .rdata_flat     (rdata_flat),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .look_idx       (look_idx),
        .look_tag       (look_tag),
        .cpu_stall      (cpu_stall),
        .hit_way        (hit_way),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .tag_fill_en    (tag_fill_en),
        .tag_fill_way   (tag_fill_way),
        .dirty_mark_en  (dirty_mark_en),
        .dirty_mark_way (dirty_mark_way),
        .data_we        (data_we),
        .data_way       (data_way),
        .data_wdata     (data_wdata),
        .touch_en       (touch_en),
        .touch_way      (touch_way)
    );

    assign cpu_rdata = rdata_flat[hit_way*WORD_W +: WORD_W];

endmodule

// File: rtl/sa2c_checker.sv
module sa2c_checker (
    input logic        clk,
    input logic        rst,
    input logic        cpu_req,
    input logic [31:0] cpu_addr,
    input logic        cpu_stall,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [1:0]  hit_vec
);

    // R2: the two tag comparators never both match
    assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R10: an unanswered memory request keeps all its fields
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

    // R5: an acknowledged write-back is followed by the fill read
    assert_wb_then_fill_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    // R9: the processor is held while memory is busy
    assert_mem_stall_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cpu_stall);

    // R9: after the fill the unchanged request completes
    assert_fill_done_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ack |=> !(cpu_req && $stable(cpu_addr)) || !cpu_stall);

endmodule

bind sa2_wb_cache sa2c_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .hit_vec   (hit_vec)
);

// File: tb/sa2_wb_cache_tb_top.sv
`timescale 1ns/1ps
module sa2_wb_cache_tb_top;

    localparam int AGE = 1024;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    sa2_wb_cache dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit          mv   [2][256];
    bit          md   [2][256];
    bit          mu   [2][256];
    logic [21:0] mt   [2][256];
    logic [31:0] mdat [2][256];
    int          mst = 0;       // 0 idle, 1 write-back, 2 fill
    int          mvic = 0;
    logic [31:0] mlat = '0;
    int          tcnt = 0;
    logic [31:0] bmem [logic [31:0]];

    bit          p_req = 0, p_we = 0;
    logic [31:0] p_addr = '0, p_wdata = '0;
    int          ack_wait = 0;
    int          n_rd = 0, n_wr = 0;
    logic [31:0] last_wa = '0, last_wd = '0;
    bit          e_stall = 0;
    logic [31:0] got_rd = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bget(input logic [31:0] a);
        if (bmem.exists(a)) return bmem[a];
        return a ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [31:0] mk(input int t, input int i);
        logic [21:0] tt;
        logic [7:0]  ii;
        tt = t[21:0];
        ii = i[7:0];
        return {tt, ii, 2'b00};
    endfunction

    task automatic eval_cycle();
        int          idx, li, hitw, v;
        bit          e_mreq, e_mwe;
        logic [31:0] e_maddr, e_mwd;
        cpu_req = p_req; cpu_we = p_we; cpu_addr = p_addr; cpu_wdata = p_wdata;
        if (mem_ack) begin
            mem_ack = 1'b0;
            ack_wait = 0;
        end else if (mem_req) begin
            ack_wait++;
            if (ack_wait >= LAT) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    bmem[mem_addr] = mem_wdata;
                    n_wr++;
                    last_wa = mem_addr;
                    last_wd = mem_wdata;
                end else begin
                    mem_rdata = bget(mem_addr);
                    n_rd++;
                end
            end
        end
        #1;
        idx = int'(p_addr[9:2]);
        li  = int'(mlat[9:2]);
        hitw = -1;
        e_mreq = 0; e_mwe = 0; e_maddr = '0; e_mwd = '0;
        e_stall = 0;
        if (mst == 0) begin
            if (p_req) begin
                for (int w = 0; w < 2; w++)
                    if (mv[w][idx] && mt[w][idx] == p_addr[31:10]) hitw = w;
                e_stall = (hitw < 0);
            end
        end else if (mst == 1) begin
            e_stall = 1; e_mreq = 1; e_mwe = 1;
            e_maddr = {mt[mvic][li], mlat[9:2], 2'b00};
            e_mwd = mdat[mvic][li];
        end else begin
            e_stall = 1; e_mreq = 1; e_mwe = 0;
            e_maddr = {mlat[31:2], 2'b00};
        end
        chk("R9 stall", 32'(cpu_stall), 32'(e_stall));
        chk("R10 mem_req", 32'(mem_req), 32'(e_mreq));
        if (e_mreq) begin
            chk("R5 mem_we", 32'(mem_we), 32'(e_mwe));
            chk("R10 mem_addr", mem_addr, e_maddr);
            if (e_mwe) chk("R5 write-back data", mem_wdata, e_mwd);
        end
        if (hitw >= 0 && !p_we) chk("R2 load data", cpu_rdata, mdat[hitw][idx]);
        got_rd = cpu_rdata;
        // advance the model to the state after the coming rising edge
        if (tcnt == AGE - 1) begin
            tcnt = 0;
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 256; s++) mu[w][s] = 0;
        end else begin
            tcnt++;
        end
        if (mst == 0) begin
            if (p_req) begin
                if (hitw >= 0) begin
                    mu[hitw][idx] = 1;
                    if (p_we) begin
                        mdat[hitw][idx] = p_wdata;
                        md[hitw][idx] = 1;
                    end
                end else begin
                    if (!mv[0][idx]) v = 0;
                    else if (!mv[1][idx]) v = 1;
                    else if (!mu[0][idx]) v = 0;
                    else if (!mu[1][idx]) v = 1;
                    else v = 0;
                    mvic = v;
                    mlat = p_addr;
                    mst = (mv[v][idx] && md[v][idx]) ? 1 : 2;
                end
            end
        end else if (mst == 1) begin
            if (mem_ack) mst = 2;
        end else begin
            if (mem_ack) begin
                mv[mvic][li] = 1;
                md[mvic][li] = 0;
                mt[mvic][li] = mlat[31:10];
                mdat[mvic][li] = mem_rdata;
                mst = 0;
            end
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        eval_cycle();
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd);
        p_req = 1; p_we = we; p_addr = a; p_wdata = wd;
        for (int n = 0; n < 100; n++) begin
            cycle();
            if (!e_stall) break;
        end
        rd = got_rd;
        p_req = 0;
    endtask

    task automatic wait_tick();
        for (int n = 0; n < AGE + 4; n++) begin
            cycle();
            if (tcnt == 0) break;
        end
        cycle();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int r0, w0;
        logic [31:0] A, B, C, D, E, F, G, X, Y;
        A = mk(1, 3); B = mk(2, 3); C = mk(3, 3); D = mk(4, 3);
        E = mk(5, 9); F = mk(6, 9); G = mk(7, 9);
        X = 32'hDEAD_0001; Y = 32'hBEEF_0002;

        repeat (3) @(negedge clk);
        chk("R3 reset stall", 32'(cpu_stall), 32'd0);
        chk("R3 reset mem_req", 32'(mem_req), 32'd0);
        rst = 1'b0;
        eval_cycle();

        // R3 / R6: cold miss reads memory, nothing written
        r0 = n_rd; w0 = n_wr;
        access(0, A, '0, rd);
        chk("R3 cold miss reads", n_rd - r0, 1);
        chk("R6 no write on empty victim", n_wr - w0, 0);
        chk("R9 load after fill", rd, bget(A));

        // R1: byte offsets hit the same word
        r0 = n_rd;
        access(0, A + 1, '0, rd);
        chk("R1 offset 1 data", rd, bget(A));
        access(0, A + 3, '0, rd);
        chk("R1 offset 3 data", rd, bget(A));
        chk("R1 no traffic", n_rd - r0, 0);

        // R7: second tag goes to the empty way
        access(0, B, '0, rd);
        r0 = n_rd;
        access(0, A, '0, rd);
        chk("R7 empty way taken first", n_rd - r0, 0);

        // R4: store hit
        r0 = n_rd; w0 = n_wr;
        access(1, A, X, rd);
        access(0, A, '0, rd);
        chk("R4 store hit readback", rd, X);
        chk("R4 store hit no traffic", (n_rd - r0) + (n_wr - w0), 0);

        // R5 / R7: both used -> way 0 (A, dirty) evicted with write-back
        wait_tick();
        access(0, A, '0, rd);
        access(0, B, '0, rd);
        r0 = n_rd; w0 = n_wr;
        access(0, C, '0, rd);
        chk("R5 one write-back", n_wr - w0, 1);
        chk("R5 write-back address", last_wa, A);
        chk("R5 write-back data", last_wd, X);
        chk("R5 fill after write-back", n_rd - r0, 1);
        r0 = n_rd;
        access(0, B, '0, rd);
        chk("R7 way 1 kept when both used", n_rd - r0, 0);

        // R6: clean victim (C) replaced without write
        w0 = n_wr;
        access(0, A, '0, rd);
        chk("R6 clean victim no write", n_wr - w0, 0);
        chk("R5 written word refetched", rd, X);

        // R8: after a wipe only way 0 (A) is touched, so way 1 (B) is replaced
        wait_tick();
        access(0, A, '0, rd);
        access(0, D, '0, rd);
        r0 = n_rd;
        access(0, A, '0, rd);
        chk("R8 touched way survives", n_rd - r0, 0);
        access(0, B, '0, rd);
        chk("R8 untouched way evicted", n_rd - r0, 1);

        // R9: store miss allocates then writes
        r0 = n_rd; w0 = n_wr;
        access(1, E, Y, rd);
        chk("R9 store miss fills", n_rd - r0, 1);
        chk("R9 store miss no write", n_wr - w0, 0);
        r0 = n_rd;
        access(0, E, '0, rd);
        chk("R9 store miss data", rd, Y);
        chk("R9 store miss then hit", n_rd - r0, 0);
        access(0, F, '0, rd);
        wait_tick();
        access(0, F, '0, rd);
        w0 = n_wr;
        access(0, G, '0, rd);
        chk("R9 allocated line is dirty", n_wr - w0, 1);
        chk("R4 dirty address", last_wa, E);
        chk("R4 dirty data", last_wd, Y);

        // mixed traffic over a small pool, compared every cycle
        for (int k = 0; k < 600; k++) begin
            logic [31:0] a;
            bit we;
            a = mk(int'($urandom % 4), int'($urandom % 3)) + ($urandom % 4);
            we = ($urandom % 3) == 0;
            access(we, a, $urandom, rd);
            if ($urandom % 5 == 0) cycle();
        end

        summary();
        $finish;
    end

endmodule